// File: doc/BRIEF.md
# Self-Timed Byte-Write Memory Controller

This block is the control logic of a byte-wide non-volatile memory that is accessed like a static RAM. A system clock samples three active-low strobes (chip select, output gate, write strobe), an address bus and a data bus. Reads return the addressed byte on a registered data output with a separate drive-enable. A qualified low pulse on the write strobe launches an internally timed write. The write first erases the target byte to all ones and then programs the latched value. While the write runs, a ready flag is held low. A host can either watch that flag or poll the written location, whose top bit reads inverted until the write is done.

Two flag inputs stand in for high-voltage conditions. `id_hv` opens a separate 32-byte identification row at the top 32 addresses. `clr_hv` turns a write pulse into a whole-array clear, which sets every main byte to all ones and leaves the identification row untouched. A write-strobe pulse filter rejects short glitches. A power-good input gates the start of any write or clear. Write-cycle length is a clock count, chosen from a short or long preset. The storage is a register file whose size is set by a parameter. Its contents are not reset.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: When `ce_n`=0, `oe_n`=0 and `we_n`=1 are sampled at a clock edge, `dout_en` is 1 after that edge and `dout` holds the addressed byte.
- R2: In any other pin combination, including `ce_n`=1 whatever `oe_n` is, `dout_en` is 0 and `dout` is 0x00 after the edge.
- R3: A write starts only if `ce_n`=0 and `oe_n`=1 are sampled together with the first high sample that ends a qualified strobe pulse. With `ce_n`=1, or with `oe_n`=0 and `clr_hv`=0, `rdy` stays 1 and memory is unchanged.
- R4: The address (with the identification select) is captured at the FILT_N-th consecutive low sample of `we_n`. The data is captured at the first high sample that follows. Address changes after the capture and data changes before the rise have no effect on where or what is written.
- R5: `rdy` drops after the launching edge and stays 0 for exactly WR_SHORT clock cycles, or WR_LONG when LONG_WR=1.
- R6: Each write erases the byte before programming it, so the result equals the written data whatever the old content was (0x0F written over 0xF0 reads back 0x0F).
- R7: While a write is busy, a read of the location being written returns the inverse of the latched bit 7 on `dout[7]`. After `rdy` rises, the true byte is returned.
- R8: A `we_n` low pulse of fewer than FILT_N consecutive samples starts nothing and changes no byte.
- R9: With `id_hv`=1, addresses whose upper bits are all ones (the top 32) reach a separate 32-byte row, read and written like the main array. With `id_hv`=0, the same addresses reach the main array. Neither row affects the other.
- R10: A qualified strobe pulse with `ce_n`=0 and `clr_hv`=1 at the rise starts a clear. `rdy` is 0 for CLR_CYC cycles, after which every main byte reads 0xFF and the identification row is unchanged.
- R11: With `pwr_ok`=0 at the rise, neither a write nor a clear starts.
- R12: Strobe pulses that arrive while `rdy` is 0 are ignored and do not change any byte.
- R13: After synchronous reset, `rdy`=1, `dout_en`=0 and `dout`=0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | AW | Byte address |
| din | input | DW | Write data |
| id_hv | input | 1 | Identification-row access flag |
| clr_hv | input | 1 | Whole-array clear flag |
| pwr_ok | input | 1 | Supply good; low blocks write and clear starts |
| dout | output | DW | Registered read data, 0 when not driving |
| dout_en | output | 1 | Read data drive enable |
| rdy | output | 1 | Ready (1) / busy (0) flag |

## Verification
A sequencer stuck in a busy state shows as `rdy` low for longer than the configured count. A lost start shows as `rdy` staying high on the cycle after a qualified pulse. Both are visible within one clock of the expected edge. A wrong latched address or data value appears as a polling bit 7 that does not invert, or as a wrong byte on the first read after completion. An erase or clear that hits the wrong row is seen when the identification row or a neighbouring main byte is read back.

// File: rtl/nvm_pkg.sv
// Package: shared types for the self-timed byte-write controller.
// Assumes nothing beyond the enumerations below.
package nvm_pkg;

    // Sequencer state: idle, timed byte write, or timed whole-array clear.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_CLEAR = 2'd2
    } seq_st_t;

endpackage

// File: rtl/nvm_we_filter.sv
// Write-strobe pulse filter.
// Counts consecutive low samples of we_n. Signals a qualified fall on the
// FILT_N-th low sample and a qualified rise on the first high sample after a
// qualified low. Shorter pulses produce no events.
// Assumes we_n is already synchronous to clk and FILT_N >= 1.
module nvm_we_filter #(
    parameter int FILT_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    output logic fall_o,
    output logic rise_o
);

    localparam int CW = $clog2(FILT_N + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(FILT_N);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_N - 1);

    logic [CW-1:0] low_cnt;

    // Saturating count of consecutive low samples, cleared on any high sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (we_n) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_FULL) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Event decode from the current sample and the count so far.
    always_comb begin
        fall_o = !we_n && (low_cnt == CNT_LAST);
        rise_o = we_n && (low_cnt == CNT_FULL);
    end

endmodule

// File: rtl/nvm_seq.sv
// Write / clear sequencer.
// Holds the pending strobe address and launches a timed byte write or a timed
// array clear on a qualified strobe rise. Emits one-cycle erase, program and
// clear strobes for the storage.
// Assumes WR_CYC >= 2 and CLR_CYC >= 1.
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int WR_CYC  = 12,
    parameter int CLR_CYC = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_i,
    input  logic          rise_i,
    input  logic          ce_n_i,
    input  logic          oe_n_i,
    input  logic          clr_hv_i,
    input  logic          pwr_ok_i,
    input  logic [AW-1:0] addr_i,
    input  logic          id_sel_i,
    input  logic [DW-1:0] din_i,
    output seq_st_t       st_o,
    output logic [AW-1:0] lat_addr_o,
    output logic          lat_id_o,
    output logic [DW-1:0] lat_data_o,
    output logic          erase_o,
    output logic          prog_o,
    output logic          clear_o
);

    localparam int MAXC = (WR_CYC > CLR_CYC) ? WR_CYC : CLR_CYC;
    localparam int CNTW = $clog2(MAXC + 1);
    localparam logic [CNTW-1:0] WR_LAST  = CNTW'(WR_CYC - 1);
    localparam logic [CNTW-1:0] ERASE_AT = CNTW'(WR_CYC / 2 - 1);
    localparam logic [CNTW-1:0] CLR_LAST = CNTW'(CLR_CYC - 1);

    seq_st_t         st;
    logic [CNTW-1:0] cnt;
    logic [AW-1:0]   pend_addr;
    logic            pend_id;

    // State, cycle counter, pending address capture and launch-time latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            pend_addr  <= '0;
            pend_id    <= 1'b0;
            lat_addr_o <= '0;
            lat_id_o   <= 1'b0;
            lat_data_o <= '0;
        end else begin
            if (fall_i) begin
                pend_addr <= addr_i;
                pend_id   <= id_sel_i;
            end
            unique case (st)
                ST_IDLE: begin
                    if (rise_i && !ce_n_i && pwr_ok_i) begin
                        if (clr_hv_i) begin
                            st  <= ST_CLEAR;
                            cnt <= '0;
                        end else if (oe_n_i) begin
                            st         <= ST_WRITE;
                            cnt        <= '0;
                            lat_addr_o <= pend_addr;
                            lat_id_o   <= pend_id;
                            lat_data_o <= din_i;
                        end
                    end
                end
                ST_WRITE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == WR_LAST) begin
                        st <= ST_IDLE;
                    end
                end
                ST_CLEAR: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CLR_LAST) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Phase strobes toward the storage, decoded from state and count.
    always_comb begin
        st_o    = st;
        erase_o = (st == ST_WRITE) && (cnt == ERASE_AT);
        prog_o  = (st == ST_WRITE) && (cnt == WR_LAST);
        clear_o = (st == ST_CLEAR) && (cnt == CLR_LAST);
    end

endmodule

// File: rtl/nvm_array.sv
// Storage register file: a main array of 2**AW bytes plus a separate
// identification row of ID_ROWS bytes. One write port, whole-main clear,
// asynchronous read. Contents are non-volatile in intent and are not reset.
// Assumes ID_ROWS is a power of two.
module nvm_array #(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int ID_ROWS = 32
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_id,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          clr_all,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_id,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;
    localparam int IDW   = $clog2(ID_ROWS);

    logic [DW-1:0] main_q [DEPTH];
    logic [DW-1:0] id_q   [ID_ROWS];

    // Main array: whole-array clear to ones, or a single byte write.
    always_ff @(posedge clk) begin
        if (clr_all) begin
            for (int i = 0; i < DEPTH; i++) begin
                main_q[i] <= '1;
            end
        end else if (wr_en && !wr_id) begin
            main_q[wr_addr] <= wr_data;
        end
    end

    // Identification row: byte writes only, untouched by the clear.
    always_ff @(posedge clk) begin
        if (wr_en && wr_id) begin
            id_q[wr_addr[IDW-1:0]] <= wr_data;
        end
    end

    // Read select between the two rows.
    always_comb begin
        rd_data = rd_id ? id_q[rd_addr[IDW-1:0]] : main_q[rd_addr];
    end

endmodule

// File: rtl/nvm_byte_ctrl.sv
// Top: self-timed byte-write memory controller with a static-RAM-like pin set.
// Samples strobes on clk, filters the write strobe, sequences timed
// erase-then-program writes and array clears, and drives registered read data
// with bit-7 completion polling.
// Assumes all pins are synchronous to clk, AW > log2(ID_ROWS), WR_* >= 2.
module nvm_byte_ctrl
    import nvm_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int ID_ROWS  = 32,
    parameter int FILT_N   = 3,
    parameter int WR_SHORT = 12,
    parameter int WR_LONG  = 48,
    parameter bit LONG_WR  = 1'b0,
    parameter int CLR_CYC  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          id_hv,
    input  logic          clr_hv,
    input  logic          pwr_ok,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          rdy
);

    localparam int IDW    = $clog2(ID_ROWS);
    localparam int WR_CYC = LONG_WR ? WR_LONG : WR_SHORT;

    logic          fall, rise;
    seq_st_t       st;
    logic [AW-1:0] lat_addr;
    logic          lat_id;
    logic [DW-1:0] lat_data;
    logic          erase, prog, clear;
    logic          id_sel;
    logic [DW-1:0] rd_data;
    logic          rd_req;
    logic          poll_hit;

    nvm_we_filter #(
        .FILT_N (FILT_N)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_n   (we_n),
        .fall_o (fall),
        .rise_o (rise)
    );

    nvm_seq #(
        .AW      (AW),
        .DW      (DW),
        .WR_CYC  (WR_CYC),
        .CLR_CYC (CLR_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall),
        .rise_i     (rise),
        .ce_n_i     (ce_n),
        .oe_n_i     (oe_n),
        .clr_hv_i   (clr_hv),
        .pwr_ok_i   (pwr_ok),
        .addr_i     (addr),
        .id_sel_i   (id_sel),
        .din_i      (din),
        .st_o       (st),
        .lat_addr_o (lat_addr),
        .lat_id_o   (lat_id),
        .lat_data_o (lat_data),
        .erase_o    (erase),
        .prog_o     (prog),
        .clear_o    (clear)
    );

    nvm_array #(
        .AW      (AW),
        .DW      (DW),
        .ID_ROWS (ID_ROWS)
    ) u_mem (
        .clk     (clk),
        .wr_en   (erase | prog),
        .wr_id   (lat_id),
        .wr_addr (lat_addr),
        .wr_data (prog ? lat_data : {DW{1'b1}}),
        .clr_all (clear),
        .rd_addr (addr),
        .rd_id   (id_sel),
        .rd_data (rd_data)
    );

    // Row select, read qualification and polling match for the current pins.
    always_comb begin
        id_sel   = id_hv && (&addr[AW-1:IDW]);
        rd_req   = !ce_n && !oe_n && we_n;
        poll_hit = (st == ST_WRITE) && (addr == lat_addr) && (id_sel == lat_id);
        rdy      = (st == ST_IDLE);
    end

    // Registered read output: polling word, stored byte, or quiet zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_en <= 1'b0;
            dout    <= '0;
        end else begin
            dout_en <= rd_req;
            if (!rd_req) begin
                dout <= '0;
            end else if (poll_hit) begin
                dout <= {~lat_data[DW-1], {(DW-1){1'b0}}};
            end else begin
                dout <= rd_data;
            end
        end
    end

endmodule

// File: rtl/nvm_byte_ctrl_chk.sv
// Checker: port-level properties of the controller, bound to every instance.
module nvm_byte_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          clr_hv,
    input logic          pwr_ok,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          rdy
);

    // R1: a read combination enables the output after the edge.
    a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dout_en);

    // R2: chip deselected means no drive on the next cycle.
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_en);

    // R2: undriven output carries zero.
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    // R3: chip deselected inhibits any start.
    a_r3_inhibit_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && ce_n) |=> rdy);

    // R3: output gate low without the clear flag inhibits a start.
    a_r3_inhibit_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !oe_n && !clr_hv) |=> rdy);

    // R8: a start needs the strobe back high on the launching sample.
    a_r8_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !we_n) |=> rdy);

    // R11: no start without good power.
    a_r11_power_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !pwr_ok) |=> rdy);

endmodule

bind nvm_byte_ctrl nvm_byte_ctrl_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .clr_hv  (clr_hv),
    .pwr_ok  (pwr_ok),
    .dout    (dout),
    .dout_en (dout_en),
    .rdy     (rdy)
);

// File: tb/nvm_byte_ctrl_tb.sv
// Bench: vector table of writes/reads, then directed corner-case tests.
module nvm_byte_ctrl_tb;

    localparam int FN   = 3;
    localparam int WRS  = 12;
    localparam int CLRC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0] addr = '0, din = '0;
    logic       id_hv = 1'b0, clr_hv = 1'b0, pwr_ok = 1'b1;
    logic [7:0] dout;
    logic       dout_en, rdy;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    nvm_byte_ctrl #(
        .AW(8), .DW(8), .ID_ROWS(32), .FILT_N(FN),
        .WR_SHORT(WRS), .WR_LONG(48), .LONG_WR(1'b0), .CLR_CYC(CLRC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .id_hv(id_hv), .clr_hv(clr_hv),
        .pwr_ok(pwr_ok), .dout(dout), .dout_en(dout_en), .rdy(rdy)
    );

    typedef struct packed {
        logic       rd;
        logic [7:0] a;
        logic [7:0] d;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 8'hA5},
        '{1'b0, 8'h01, 8'h5A},
        '{1'b0, 8'hFF, 8'h00},
        '{1'b1, 8'h00, 8'hA5},
        '{1'b1, 8'h01, 8'h5A},
        '{1'b0, 8'h01, 8'hF0},
        '{1'b0, 8'h01, 8'h0F},
        '{1'b1, 8'h01, 8'h0F},
        '{1'b0, 8'h7F, 8'h80},
        '{1'b1, 8'h7F, 8'h80},
        '{1'b1, 8'hFF, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    // One strobe pulse of nlow low samples; returns at the negedge after the rise sample.
    task automatic pulse(input logic [7:0] a, input logic [7:0] d, input bit id,
                         input bit clr, input bit ce, input bit oe, input int nlow);
        @(negedge clk);
        ce_n = ce; oe_n = oe; addr = a; din = d; id_hv = id; clr_hv = clr; we_n = 1'b0;
        repeat (nlow) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; clr_hv = 1'b0; id_hv = 1'b0;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (!rdy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit id);
        int n;
        pulse(a, d, id, 1'b0, 1'b0, 1'b1, FN);
        wait_busy(n);
        check(n == WRS, "R5 busy length", n, WRS);
    endtask

    task automatic rd(input logic [7:0] a, input bit id, output logic [7:0] v, output logic en);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a; id_hv = id;
        @(negedge clk);
        v = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1; id_hv = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input bit id, input logic [7:0] exp_v, input string req);
        logic [7:0] v;
        logic en;
        rd(a, id, v, en);
        check(en === 1'b1 && v === exp_v, req, {en, v}, {1'b1, exp_v});
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic en;
        int n;

        // R13: reset state while read pins are active.
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        check(rdy === 1'b1 && dout_en === 1'b0 && dout === 8'h00, "R13 reset state",
              {rdy, dout_en, dout}, {1'b1, 1'b0, 8'h00});
        ce_n = 1'b1; oe_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R1 reads, R6 overwrite 0xF0 by 0x0F.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) rd_chk(VEC[i].a, 1'b0, VEC[i].d, "R1/R6 table read");
            else wr(VEC[i].a, VEC[i].d, 1'b0);
        end

        // R2: output gate high, and chip deselected with gate low.
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; addr = 8'h00;
        @(negedge clk);
        check(dout_en === 1'b0 && dout === 8'h00, "R2 gate high", {dout_en, dout}, 0);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        check(dout_en === 1'b0 && dout === 8'h00, "R2 standby", {dout_en, dout}, 0);
        oe_n = 1'b1;

        // R7: polling on bit 7 for both polarities.
        pulse(8'h10, 8'h35, 1'b0, 1'b0, 1'b0, 1'b1, FN);
        rd(8'h10, 1'b0, v, en);
        check(en === 1'b1 && v[7] === 1'b1 && rdy === 1'b0, "R7 poll inverted 0", v[7], 1);
        wait_busy(n);
        rd_chk(8'h10, 1'b0, 8'h35, "R7 true data after");
        pulse(8'h11, 8'hC8, 1'b0, 1'b0, 1'b0, 1'b1, FN);
        rd(8'h11, 1'b0, v, en);
        check(en === 1'b1 && v[7] === 1'b0, "R7 poll inverted 1", v[7], 0);
        wait_busy(n);
        rd_chk(8'h11, 1'b0, 8'hC8, "R7 true data after");

        // R4: address at filtered fall, data at rise.
        wr(8'h41, 8'h3C, 1'b0);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; addr = 8'h40; din = 8'h12; we_n = 1'b0;
        repeat (FN) @(negedge clk);
        addr = 8'h41; din = 8'h6C;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        wait_busy(n);
        check(n == WRS, "R4 busy", n, WRS);
        rd_chk(8'h40, 1'b0, 8'h6C, "R4 late data at latched address");
        rd_chk(8'h41, 1'b0, 8'h3C, "R4 later address untouched");

        // R8: short pulse is ignored.
        wr(8'h50, 8'h44, 1'b0);
        pulse(8'h50, 8'hBB, 1'b0, 1'b0, 1'b0, 1'b1, FN - 1);
        check(rdy === 1'b1, "R8 no busy after glitch", rdy, 1);
        rd_chk(8'h50, 1'b0, 8'h44, "R8 byte unchanged");

        // R3: chip deselected and gate low each inhibit.
        pulse(8'h50, 8'hBB, 1'b0, 1'b0, 1'b1, 1'b1, FN);
        check(rdy === 1'b1, "R3 ce high inhibit", rdy, 1);
        pulse(8'h50, 8'hBB, 1'b0, 1'b0, 1'b0, 1'b0, FN);
        check(rdy === 1'b1, "R3 oe low inhibit", rdy, 1);
        rd_chk(8'h50, 1'b0, 8'h44, "R3 byte unchanged");

        // R11: power not good blocks write and clear.
        pwr_ok = 1'b0;
        pulse(8'h50, 8'hBB, 1'b0, 1'b0, 1'b0, 1'b1, FN);
        check(rdy === 1'b1, "R11 write blocked", rdy, 1);
        pulse(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, FN);
        check(rdy === 1'b1, "R11 clear blocked", rdy, 1);
        pwr_ok = 1'b1;
        rd_chk(8'h50, 1'b0, 8'h44, "R11 byte unchanged");

        // R12: pulse while busy is ignored.
        wr(8'h31, 8'h99, 1'b0);
        pulse(8'h30, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, FN);
        pulse(8'h31, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, FN);
        wait_busy(n);
        rd_chk(8'h30, 1'b0, 8'h11, "R12 first write done");
        rd_chk(8'h31, 1'b0, 8'h99, "R12 busy pulse ignored");

        // R9: identification row separate from main top addresses.
        wr(8'hE5, 8'h5A, 1'b1);
        wr(8'hE5, 8'hC3, 1'b0);
        wr(8'hF0, 8'h77, 1'b1);
        rd_chk(8'hE5, 1'b1, 8'h5A, "R9 id row read");
        rd_chk(8'hE5, 1'b0, 8'hC3, "R9 main row read");
        rd_chk(8'hF0, 1'b1, 8'h77, "R9 id row second");

        // R10: chip clear, id row preserved.
        pulse(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, FN);
        wait_busy(n);
        check(n == CLRC, "R10 clear busy length", n, CLRC);
        rd_chk(8'hE5, 1'b0, 8'hFF, "R10 main top cleared");
        rd_chk(8'h01, 1'b0, 8'hFF, "R10 main low cleared");
        rd_chk(8'hE5, 1'b1, 8'h5A, "R10 id row kept");
        rd_chk(8'hF0, 1'b1, 8'h77, "R10 id row kept");

        finish_run();
    end

endmodule